// File: doc/BRIEF.md
# Phase-Change Memory Bank Scheduler

This block sits in front of one phase-change memory bank and decides which request the bank serves next. Three request queues feed it: reads, writes and address-only pre-set requests. A pre-set performs the slow SET transition on a line ahead of time. A later write to that line then needs only the fast RESET transition. The bank runs one operation at a time. A busy timer models the array, and the timer length depends on the kind of operation.

Reads go ahead of writes, unless the write queue has filled up. Pre-sets use only the idle time of the bank. A pre-set never starts while reads or writes are waiting. If a read arrives while a pre-set is running, the pre-set is abandoned and run again later. The block keeps a small record of lines whose pre-set has finished. When a write is issued, the block checks that record to decide between a slow full write and a fast RESET-only write.

Top module: `pcm_bank_sched`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy`, `iss_valid`, `cpl_valid` and all three queue-full flags are 0.
- R2: The bank serves one operation at a time. When idle with the write queue not full, a waiting read is issued before any waiting write.
- R3: A read's completion pulse comes exactly RD_LAT cycles after its issue pulse (default 500).
- R4: A write to a line with no recorded pre-set is a full write (op 1). Its completion comes FULL_LAT cycles after issue (default 4000, eight times the read).
- R5: A write to a line whose pre-set has completed is a fast write (op 2). Its completion comes FAST_LAT cycles after issue (default 500). Issuing it consumes the record, so the next write to that line is full. Up to TRACK_N lines are remembered, and the oldest slot is replaced round-robin.
- R6: A pre-set (op 3) is issued only when the read and write queues are both empty. It completes PS_LAT cycles after issue, and its completion reports op 3 with its address.
- R7: If a read is waiting while a pre-set runs, the pre-set stops at the next edge with no completion pulse. Its address stays at the head of the pre-set queue, and it is run again from the start once the bank is otherwise idle.
- R8: Each queue raises its full flag when it holds its depth of entries (defaults: reads 8, writes 32, pre-sets 8). A push while full is ignored.
- R9: When the bank is idle and the write queue is full, the head write is issued ahead of any waiting read.
- R10: A write that has been issued always runs to completion. Reads arriving meanwhile wait for its completion pulse.
- R11: Op codes are 0 read, 1 full write, 2 fast write, 3 pre-set. A request pushed into an empty, idle block gets its one-cycle issue pulse two cycles after the push cycle. `iss_op` and `iss_addr` are valid with `iss_valid`, and `cpl_op` and `cpl_addr` are valid with `cpl_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_push | input | 1 | Push a read request |
| rd_addr | input | AW | Read line address |
| rd_full | output | 1 | Read queue full |
| wr_push | input | 1 | Push a write request |
| wr_addr | input | AW | Write line address |
| wr_full | output | 1 | Write queue full |
| ps_push | input | 1 | Push a pre-set request |
| ps_addr | input | AW | Pre-set line address |
| ps_full | output | 1 | Pre-set queue full |
| iss_valid | output | 1 | One-cycle pulse: operation issued to the bank |
| iss_op | output | 2 | Issued operation code |
| iss_addr | output | AW | Issued line address |
| cpl_valid | output | 1 | One-cycle pulse: operation completed |
| cpl_op | output | 2 | Completed operation code |
| cpl_addr | output | AW | Completed line address |
| busy | output | 1 | Bank occupied |

## Verification
An issue pulse is due two edges after the push that fills an empty, idle block. One edge moves the entry into the queue, and the next makes the decision. A completion is due exactly the operation's latency in edges after its issue pulse. After a completion, the next issue comes one edge later, and after a pre-set abort it also comes one edge later. The bench keeps a behavioural model, advanced on each rising edge, that follows these counts. It compares every output on the falling edge, so each result is checked in the cycle it is due. Directed sequences then check the logged issue and completion cycles against these distances and against the required ordering.

// File: rtl/pcm_sched_pkg.sv
package pcm_sched_pkg;
  typedef enum logic [1:0] {
    OP_READ    = 2'd0,
    OP_WR_FULL = 2'd1,
    OP_WR_FAST = 2'd2,
    OP_PRESET  = 2'd3
  } op_t;
endpackage

// File: rtl/pcm_req_fifo.sv
module pcm_req_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  // storage without reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/pcm_preset_track.sv
module pcm_preset_track #(
  parameter int AW = 16,
  parameter int N  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ins,
  input  logic [AW-1:0] ins_addr,
  input  logic [AW-1:0] look_addr,
  input  logic          clr,
  output logic          look_hit
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  vld;
  logic [AW-1:0] tag [N];
  logic [N-1:0]  look_m, ins_m;
  logic [IW-1:0] rr, slot;
  logic          have_free;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign look_m[g] = vld[g] && (tag[g] == look_addr);
    assign ins_m[g]  = vld[g] && (tag[g] == ins_addr);
  end

  assign look_hit = |look_m;

  always_comb begin
    have_free = 1'b0;
    slot      = rr;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        have_free = 1'b1;
        slot      = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      rr  <= '0;
    end else begin
      if (clr) vld <= vld & ~look_m;
      if (ins && !(|ins_m)) begin
        vld[slot] <= 1'b1;
        tag[slot] <= ins_addr;
        if (!have_free) rr <= (rr == IW'(N - 1)) ? '0 : rr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_busy_timer.sv
module pcm_busy_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] load,
  input  logic          abort,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0) && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= load;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pcm_bank_sched.sv
module pcm_bank_sched
  import pcm_sched_pkg::*;
#(
  parameter int AW       = 16,
  parameter int RD_DEPTH = 8,
  parameter int WR_DEPTH = 32,
  parameter int PS_DEPTH = 8,
  parameter int TRACK_N  = 8,
  parameter int RD_LAT   = 500,
  parameter int FULL_LAT = 4000,
  parameter int FAST_LAT = 500,
  parameter int PS_LAT   = 4000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_push,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_full,
  input  logic          wr_push,
  input  logic [AW-1:0] wr_addr,
  output logic          wr_full,
  input  logic          ps_push,
  input  logic [AW-1:0] ps_addr,
  output logic          ps_full,
  output logic          iss_valid,
  output logic [1:0]    iss_op,
  output logic [AW-1:0] iss_addr,
  output logic          cpl_valid,
  output logic [1:0]    cpl_op,
  output logic [AW-1:0] cpl_addr,
  output logic          busy
);
  localparam int MAX_A   = (RD_LAT > FAST_LAT) ? RD_LAT : FAST_LAT;
  localparam int MAX_B   = (FULL_LAT > PS_LAT) ? FULL_LAT : PS_LAT;
  localparam int MAX_LAT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW      = (MAX_LAT > 2) ? $clog2(MAX_LAT) : 1;

  logic [AW-1:0] rd_head, wr_head, ps_head;
  logic          rd_empty, wr_empty, ps_empty;
  logic          rd_pop, wr_pop, ps_pop;
  logic          pick_rd, pick_wr, pick_ps, start;
  logic          trk_hit, abort, run_busy, tm_done;
  op_t           sel_op, cur_op;
  logic [AW-1:0] sel_addr, cur_addr;
  logic [CW-1:0] sel_cnt;

  pcm_req_fifo #(.W(AW), .DEPTH(RD_DEPTH)) u_rdq (
    .clk(clk), .rst(rst), .push(rd_push), .pop(rd_pop), .din(rd_addr),
    .dout(rd_head), .full(rd_full), .empty(rd_empty));

  pcm_req_fifo #(.W(AW), .DEPTH(WR_DEPTH)) u_wrq (
    .clk(clk), .rst(rst), .push(wr_push), .pop(wr_pop), .din(wr_addr),
    .dout(wr_head), .full(wr_full), .empty(wr_empty));

  pcm_req_fifo #(.W(AW), .DEPTH(PS_DEPTH)) u_psq (
    .clk(clk), .rst(rst), .push(ps_push), .pop(ps_pop), .din(ps_addr),
    .dout(ps_head), .full(ps_full), .empty(ps_empty));

  pcm_preset_track #(.AW(AW), .N(TRACK_N)) u_trk (
    .clk(clk), .rst(rst),
    .ins(ps_pop), .ins_addr(cur_addr),
    .look_addr(wr_head), .clr(pick_wr && trk_hit),
    .look_hit(trk_hit));

  pcm_busy_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .start(start), .load(sel_cnt), .abort(abort),
    .busy(run_busy), .done(tm_done));

  // priority: full write queue, then reads, then writes, then pre-sets
  always_comb begin
    pick_rd = 1'b0;
    pick_wr = 1'b0;
    pick_ps = 1'b0;
    if (!run_busy) begin
      if (wr_full)        pick_wr = 1'b1;
      else if (!rd_empty) pick_rd = 1'b1;
      else if (!wr_empty) pick_wr = 1'b1;
      else if (!ps_empty) pick_ps = 1'b1;
    end
  end

  assign start  = pick_rd || pick_wr || pick_ps;
  assign rd_pop = pick_rd;
  assign wr_pop = pick_wr;
  assign abort  = run_busy && (cur_op == OP_PRESET) && !rd_empty;
  assign ps_pop = tm_done && (cur_op == OP_PRESET);

  always_comb begin
    if (pick_rd) begin
      sel_op   = OP_READ;
      sel_addr = rd_head;
      sel_cnt  = CW'(RD_LAT - 1);
    end else if (pick_wr && trk_hit) begin
      sel_op   = OP_WR_FAST;
      sel_addr = wr_head;
      sel_cnt  = CW'(FAST_LAT - 1);
    end else if (pick_wr) begin
      sel_op   = OP_WR_FULL;
      sel_addr = wr_head;
      sel_cnt  = CW'(FULL_LAT - 1);
    end else begin
      sel_op   = OP_PRESET;
      sel_addr = ps_head;
      sel_cnt  = CW'(PS_LAT - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_op    <= OP_READ;
      cur_addr  <= '0;
      iss_valid <= 1'b0;
      iss_op    <= 2'd0;
      iss_addr  <= '0;
      cpl_valid <= 1'b0;
      cpl_op    <= 2'd0;
      cpl_addr  <= '0;
    end else begin
      iss_valid <= start;
      cpl_valid <= tm_done;
      if (start) begin
        cur_op   <= sel_op;
        cur_addr <= sel_addr;
        iss_op   <= sel_op;
        iss_addr <= sel_addr;
      end
      if (tm_done) begin
        cpl_op   <= cur_op;
        cpl_addr <= cur_addr;
      end
    end
  end

  assign busy = run_busy;
endmodule

// File: rtl/pcm_bank_sched_chk.sv
module pcm_bank_sched_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       iss_valid,
  input logic [1:0] iss_op,
  input logic       cpl_valid,
  input logic       wr_full,
  input logic       rd_waiting,
  input logic       wr_waiting,
  input logic [1:0] run_op
);
  AST_ISSUE_MARKS_BUSY: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> busy); // R2
  AST_ISSUE_NOT_WITH_COMPLETE: assert property (@(posedge clk) disable iff (rst)
    !(iss_valid && cpl_valid)); // R11
  AST_COMPLETE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    cpl_valid |-> (!busy && $past(busy))); // R3
  AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !wr_full && rd_waiting) |=> (iss_valid && iss_op == 2'd0)); // R2
  AST_FULL_WRQ_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_full) |=> (iss_valid && (iss_op == 2'd1 || iss_op == 2'd2))); // R9
  AST_PRESET_ABORTS: assert property (@(posedge clk) disable iff (rst)
    (busy && run_op == 2'd3 && rd_waiting) |=> (!busy && !cpl_valid)); // R7
  AST_PRESET_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_op == 2'd3) |-> $past(!rd_waiting && !wr_waiting)); // R6
  AST_WRITE_RUNS_OUT: assert property (@(posedge clk) disable iff (rst)
    (busy && (run_op == 2'd1 || run_op == 2'd2)) |=> (busy || cpl_valid)); // R10
endmodule

bind pcm_bank_sched pcm_bank_sched_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .iss_valid(iss_valid), .iss_op(iss_op),
  .cpl_valid(cpl_valid), .wr_full(wr_full), .rd_waiting(!rd_empty),
  .wr_waiting(!wr_empty), .run_op(cur_op));

// File: tb/pcm_bank_sched_tb.sv
module pcm_bank_sched_tb_top;
  localparam int AW = 8, RDD = 4, WRD = 4, PSD = 4, TRK = 8;
  localparam int RDL = 10, FULLL = 80, FASTL = 8, PSL = 80;

  logic clk = 1'b0, rst = 1'b1;
  logic rd_push = 0, wr_push = 0, ps_push = 0;
  logic [AW-1:0] rd_addr = 0, wr_addr = 0, ps_addr = 0;
  logic rd_full, wr_full, ps_full, iss_valid, cpl_valid, busy;
  logic [1:0] iss_op, cpl_op;
  logic [AW-1:0] iss_addr, cpl_addr;

  always #2.5 clk = ~clk;

  pcm_bank_sched #(.AW(AW), .RD_DEPTH(RDD), .WR_DEPTH(WRD), .PS_DEPTH(PSD),
    .TRACK_N(TRK), .RD_LAT(RDL), .FULL_LAT(FULLL), .FAST_LAT(FASTL), .PS_LAT(PSL)) dut_i (
    .clk(clk), .rst(rst), .rd_push(rd_push), .rd_addr(rd_addr), .rd_full(rd_full),
    .wr_push(wr_push), .wr_addr(wr_addr), .wr_full(wr_full),
    .ps_push(ps_push), .ps_addr(ps_addr), .ps_full(ps_full),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_addr(iss_addr),
    .cpl_valid(cpl_valid), .cpl_op(cpl_op), .cpl_addr(cpl_addr), .busy(busy));

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  // ---------------- behavioural reference model ----------------
  logic [AW-1:0] q_rd[$], q_wr[$], q_ps[$];
  bit trk[int];
  bit m_busy; int m_cnt, m_op; logic [AW-1:0] m_addr;
  bit e_iss, e_cpl; int e_iop, e_cop; logic [AW-1:0] e_iaddr, e_caddr;

  always @(posedge clk) begin
    bit frd, fwr, fps;
    cyc++;
    frd = (q_rd.size() == RDD); fwr = (q_wr.size() == WRD); fps = (q_ps.size() == PSD);
    e_iss = 0; e_cpl = 0;
    if (rst) begin
      q_rd.delete(); q_wr.delete(); q_ps.delete(); trk.delete(); m_busy = 0;
    end else begin
      if (m_busy) begin
        if (m_op == 3 && q_rd.size() > 0) m_busy = 0;
        else if (m_cnt == 0) begin
          m_busy = 0; e_cpl = 1; e_cop = m_op; e_caddr = m_addr;
          if (m_op == 3) begin void'(q_ps.pop_front()); trk[int'(m_addr)] = 1; end
        end else m_cnt--;
      end else begin
        int lat; bit go; go = 1;
        if (fwr || (q_rd.size() == 0 && q_wr.size() > 0)) begin
          m_addr = q_wr.pop_front();
          if (trk.exists(int'(m_addr))) begin m_op = 2; lat = FASTL; trk.delete(int'(m_addr)); end
          else begin m_op = 1; lat = FULLL; end
        end else if (q_rd.size() > 0) begin m_addr = q_rd.pop_front(); m_op = 0; lat = RDL; end
        else if (q_ps.size() > 0) begin m_addr = q_ps[0]; m_op = 3; lat = PSL; end
        else go = 0;
        if (go) begin m_busy = 1; m_cnt = lat - 1; e_iss = 1; e_iop = m_op; e_iaddr = m_addr; end
      end
      if (rd_push && !frd) q_rd.push_back(rd_addr);
      if (wr_push && !fwr) q_wr.push_back(wr_addr);
      if (ps_push && !fps) q_ps.push_back(ps_addr);
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if ({rd_full, wr_full, ps_full} !== {q_rd.size() == RDD, q_wr.size() == WRD, q_ps.size() == PSD}) begin
        errors++; $display("FAIL R8 full flags got %b exp %b", {rd_full, wr_full, ps_full},
          {q_rd.size() == RDD, q_wr.size() == WRD, q_ps.size() == PSD});
      end
      checks++;
      if (iss_valid !== e_iss || (e_iss && (iss_op !== 2'(e_iop) || iss_addr !== e_iaddr))) begin
        errors++; $display("FAIL R2 issue got v%0b op%0d a%0h exp v%0b op%0d a%0h",
          iss_valid, iss_op, iss_addr, e_iss, e_iop, e_iaddr);
      end
      checks++;
      if (cpl_valid !== e_cpl || (e_cpl && (cpl_op !== 2'(e_cop) || cpl_addr !== e_caddr))) begin
        errors++; $display("FAIL R3 completion got v%0b op%0d a%0h exp v%0b op%0d a%0h",
          cpl_valid, cpl_op, cpl_addr, e_cpl, e_cop, e_caddr);
      end
      checks++;
      if (busy !== (m_busy && !rst)) begin
        errors++; $display("FAIL R10 busy got %0b exp %0b", busy, m_busy);
      end
    end
  end

  // ---------------- event logs ----------------
  typedef struct { int c; int op; int a; } ev_t;
  ev_t li[$], lc[$];
  always @(negedge clk) begin
    if (iss_valid) li.push_back('{cyc, int'(iss_op), int'(iss_addr)});
    if (cpl_valid) lc.push_back('{cyc, int'(cpl_op), int'(cpl_addr)});
  end

  task automatic chk(input string r, input int got, input int exp);
    checks++;
    if (got != exp) begin errors++; $display("FAIL %s got %0d exp %0d", r, got, exp); end
  endtask

  task automatic drive(input bit rv, input int ra, input bit wv, input int wa,
                       input bit pv, input int pa);
    @(negedge clk);
    rd_push = rv; rd_addr = AW'(ra); wr_push = wv; wr_addr = AW'(wa);
    ps_push = pv; ps_addr = AW'(pa);
    @(negedge clk);
    rd_push = 0; wr_push = 0; ps_push = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_logs();
    li.delete(); lc.delete();
  endtask

  initial begin
    int pc;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 0); chk("R1 iss", iss_valid, 0); chk("R1 cpl", cpl_valid, 0);
    chk("R1 fulls", {rd_full, wr_full, ps_full}, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);

    // R3 / R11: lone read
    clear_logs(); pc = cyc + 1;
    drive(1, 'h11, 0, 0, 0, 0); run(15);
    chk("R11 read issue delay", li[0].c - pc, 2);
    chk("R11 read op", li[0].op, 0);
    chk("R3 read latency", lc[0].c - li[0].c, RDL);

    // R4: full write
    clear_logs(); drive(0, 0, 1, 'h20, 0, 0); run(FULLL + 6);
    chk("R4 write op", li[0].op, 1);
    chk("R4 full write latency", lc[0].c - li[0].c, FULLL);

    // R6 / R5: pre-set then fast write, then full again
    clear_logs(); drive(0, 0, 0, 0, 1, 'h21); run(PSL + 6);
    chk("R6 preset op", li[0].op, 3);
    chk("R6 preset latency", lc[0].c - li[0].c, PSL);
    chk("R6 preset cpl addr", lc[0].a, 'h21);
    clear_logs(); drive(0, 0, 1, 'h21, 0, 0); run(FASTL + 6);
    chk("R5 fast write op", li[0].op, 2);
    chk("R5 fast write latency", lc[0].c - li[0].c, FASTL);
    clear_logs(); drive(0, 0, 1, 'h21, 0, 0); run(FULLL + 6);
    chk("R5 record consumed", li[0].op, 1);

    // R6: pre-set waits behind read
    clear_logs(); drive(1, 'h12, 0, 0, 1, 'h22); run(RDL + PSL + 10);
    chk("R6 read first", li[0].op, 0);
    chk("R6 preset second", li[1].op, 3);
    chk("R6 preset after read done", int'(li[1].c > lc[0].c), 1);
    drive(0, 0, 1, 'h22, 0, 0); run(FASTL + 6);

    // R7: read aborts pre-set
    clear_logs(); drive(0, 0, 0, 0, 1, 'h30); run(8);
    drive(1, 'h13, 0, 0, 0, 0); run(RDL + PSL + 10);
    chk("R7 first completion is read", lc[0].op, 0);
    chk("R7 issue count", li.size(), 3);
    chk("R7 rerun op", li[2].op, 3);
    chk("R7 rerun addr", li[2].a, 'h30);
    chk("R7 preset completes once", lc.size(), 2);
    drive(0, 0, 1, 'h30, 0, 0); run(FASTL + 6);

    // R8 / R9 / R10 / R2: full write queue and ordering
    clear_logs();
    drive(1, 'h14, 0, 0, 0, 0);
    drive(0, 0, 1, 'h40, 0, 0); drive(0, 0, 1, 'h41, 0, 0);
    drive(0, 0, 1, 'h42, 0, 0);
    @(negedge clk); wr_push = 1; wr_addr = 'h43;
    @(negedge clk); wr_push = 0;
    chk("R8 wr_full raised", wr_full, 1);
    drive(0, 0, 1, 'h44, 0, 0);
    drive(1, 'h15, 0, 0, 0, 0);
    run(20);
    drive(1, 'h16, 0, 0, 0, 0);
    run(2 * RDL + 4 * FULLL + 40);
    chk("R9 write before read 15", li[1].a, 'h40);
    chk("R2 read 15 next", li[2].a, 'h15);
    chk("R2 read 16 next", li[3].a, 'h16);
    chk("R10 read waits for write", int'(li[3].c > lc[1].c), 1);
    chk("R8 dropped push", li.size(), 7);
    chk("R8 last write", li[6].a, 'h43);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      rd_push = ($urandom % 20) == 0; rd_addr = AW'($urandom);
      wr_push = ($urandom % 25) == 0; wr_addr = AW'($urandom % 8);
      ps_push = ($urandom % 10) == 0; ps_addr = AW'($urandom % 4);
    end
    @(negedge clk); rd_push = 0; wr_push = 0; ps_push = 0;
    run(5 * FULLL);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1; checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule